// File: doc/BRIEF.md
# Second-Aligned Sample Timing Engine

This block turns a disciplined 8 MHz system clock into the sample strobes of a three-channel converter front end. It runs at 8.000 kHz, one strobe every 1000 clocks. A raw once-per-second pulse arrives from a separate, drifting timing domain. It is brought into the clock domain through a two-stage synchronizer. Its rising edge then hard-restarts the divider, so that every second begins with one freshly aligned block of sample sets.

With each strobe the block presents an absolute timestamp made of two parts: the count of seconds and the position of the sample set inside the current second. If a pulse is late, the block stops strobing once the block is full and raises a missing flag. If a pulse comes early, the block cuts the current second short and flags it for one cycle. Software can preset the seconds count; the new value takes over at the next second boundary. The block is meant to sit between the timing receiver and the converter sequencer, which starts one conversion of all channels on each strobe.

Top module: `pps_sample_engine`

## Requirements
- R1: After a synchronous active-low reset, every output is 0 (strobe, channel requests, index, seconds, pulse-seen, missing, short). No strobe is issued until the first second boundary has been detected.
- R2: The raw pulse passes through two synchronizing flip-flops and an edge register. If the pulse is first sampled high at rising clock edge k, the boundary takes effect at edge k+2, so the first strobe is visible after edge k+2. Only a 0-to-1 change counts: a pulse held high gives exactly one boundary.
- R3: On a boundary the index goes to 0 and the strobe is high in the next cycle. Further strobes follow every DIV cycles, each a single cycle wide, and the index rises by 1 with each strobe.
- R4: Each boundary adds 1 to the seconds count, unless a load is pending (R7).
- R5: After the strobe with index SAMPLES-1, the index holds at SAMPLES-1. No further strobe is issued, and the missing flag goes high in the cycle where the next strobe would have come. The flag stays high until the next boundary clears it.
- R6: If a boundary arrives after the first one while the index is below SAMPLES-1, the block realigns at once and the short-second flag is high for exactly one cycle. A boundary that arrives when the index is SAMPLES-1, including one that coincides with the would-be next strobe, is not short.
- R7: A cycle with load_en high stores load_sec as pending. At the next boundary the seconds count takes the pending value instead of incrementing. A load in the same cycle as a boundary stays pending for the following boundary. A load never changes the seconds count before a boundary.
- R8: pps_seen rises at the first boundary after reset and stays high.
- R9: All NCH bits of chan_req equal the sample strobe in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Disciplined system clock (8 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| pps_raw | input | 1 | Unsynchronized once-per-second pulse |
| load_en | input | 1 | Store load_sec for the next boundary |
| load_sec | input | SEC_W | Seconds value to take effect at the next boundary |
| sample_strobe | output | 1 | One-cycle sample-set request |
| chan_req | output | NCH | Per-channel conversion request |
| sample_idx | output | IDX_W | Position of the sample set within the second |
| seconds | output | SEC_W | Seconds count |
| pps_seen | output | 1 | A boundary has been detected since reset |
| pps_missing | output | 1 | Block complete and no boundary yet |
| short_second | output | 1 | One-cycle flag for an early boundary |

## Verification
The bench drives pulses with random spacing: shorter, longer and exactly equal to a full block, which is the case where the boundary lands on the cycle of the would-be next strobe. A design that let the divider win that collision would raise the missing flag or report a false short second. Pulses held high across many cycles check that a level is not taken as repeated boundaries; a design that restarts on level would never fill a block. Loads placed just before, on and between boundaries expose a seconds counter that applies the value at once or drops a load that coincides with an edge. A directed latency test counts clock edges from the pulse to the first strobe, which catches a missing or extra synchronizer stage.

// File: rtl/pps_engine_pkg.sv
// Package: pps_engine_pkg
// Shared defaults and width helpers for the second-aligned sample engine.
// Assumes every count passed to width_of is at least 1.
package pps_engine_pkg;

    // Default system clock divide for 8 MHz -> 8 kHz
    localparam int DEF_DIV     = 1000;
    // Default sample sets per second
    localparam int DEF_SAMPLES = 8000;
    // Default number of converter channels
    localparam int DEF_NCH     = 3;
    // Default seconds counter width
    localparam int DEF_SEC_W   = 32;

    // Bits needed to hold values 0..n-1, never less than 1
    function automatic int width_of(input int n);
        int w;
        w = $clog2(n);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/pps_edge_sync.sv
// Module: pps_edge_sync
// Brings the raw once-per-second pulse into the clock domain through two
// flip-flops and flags its rising edge for one cycle.
// Assumes the raw pulse stays high for at least two clock cycles.
module pps_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_raw,
    output logic pps_edge
);

    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchronizer plus a delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pps_raw;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Rising transition of the synchronized pulse
    always_comb pps_edge = sync_q & ~prev_q;

    // A level can never yield two boundaries in consecutive cycles
    assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pps_edge |=> !pps_edge);

endmodule

// File: rtl/sample_divider.sv
// Module: sample_divider
// Counts clock cycles between sample strobes. A restart forces the count to
// zero; while run is low the count rests at zero.
// Assumes DIV >= 2.
module sample_divider #(
    parameter int DIV   = pps_engine_pkg::DEF_DIV,
    localparam int CNT_W = pps_engine_pkg::width_of(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Free-running divide while enabled, hard restart on a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Period end, only while running and not being restarted
    always_comb tick = run && !restart && (cnt_q == LAST);

    assert_div_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // A restart always leaves the count at zero
    assert_div_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);

endmodule

// File: rtl/block_sequencer.sv
// Module: block_sequencer
// Tracks the position inside the current second, issues the sample strobe
// and raises the missing and short-second flags.
// Assumes a boundary and a divider tick never both act (divider masks tick).
module block_sequencer #(
    parameter int SAMPLES = pps_engine_pkg::DEF_SAMPLES,
    localparam int IDX_W  = pps_engine_pkg::width_of(SAMPLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             tick,
    output logic             run,
    output logic             strobe,
    output logic [IDX_W-1:0] idx,
    output logic             armed,
    output logic             missing,
    output logic             short_sec
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLES - 1);

    logic full;

    // Block has produced every sample set it owns
    always_comb full = (idx == LAST_IDX);

    // Divider runs between the first boundary and block completion
    always_comb run = armed && !missing;

    // Index, strobe and status state for the current second
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= '0;
            strobe    <= 1'b0;
            armed     <= 1'b0;
            missing   <= 1'b0;
            short_sec <= 1'b0;
        end else if (boundary) begin
            idx       <= '0;
            strobe    <= 1'b1;
            armed     <= 1'b1;
            missing   <= 1'b0;
            short_sec <= armed && !full;
        end else begin
            short_sec <= 1'b0;
            strobe    <= tick && !full;
            if (tick && !full) begin
                idx <= idx + 1'b1;
            end
            if (tick && full) begin
                missing <= 1'b1;
            end
        end
    end

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST_IDX);

    // Boundary yields the first strobe with index 0 one cycle later
    assert_first_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> strobe && idx == '0);

    // Missing state never coexists with a strobe, and holds the index
    assert_missing_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        missing |-> !strobe && full);

    // Short flag lasts a single cycle
    assert_short_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        short_sec |=> !short_sec);

endmodule

// File: rtl/seconds_counter.sv
// Module: seconds_counter
// Counts second boundaries; a loaded value waits in a holding register
// and replaces the increment at the next boundary.
// Assumes the counter may wrap silently at 2**SEC_W.
module seconds_counter #(
    parameter int SEC_W = pps_engine_pkg::DEF_SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    output logic [SEC_W-1:0] seconds
);

    logic             pend_q;
    logic [SEC_W-1:0] pend_val_q;

    // Seconds value: pending load wins over the increment at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seconds <= '0;
        end else if (boundary) begin
            seconds <= pend_q ? pend_val_q : seconds + 1'b1;
        end
    end

    // Holding register for a load awaiting the next boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_val_q <= '0;
        end else begin
            if (load_en) begin
                pend_val_q <= load_sec;
            end
            if (boundary) begin
                pend_q <= load_en;
            end else if (load_en) begin
                pend_q <= 1'b1;
            end
        end
    end

    assert_sec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && !pend_q |=> seconds == $past(seconds) + 1'b1);

    assert_sec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> seconds == $past(seconds));

endmodule

// File: rtl/pps_sample_engine.sv
// Module: pps_sample_engine
// Top of the second-aligned sample timing engine. Synchronizes the
// once-per-second pulse, restarts the sample divider on its rising edge
// and presents strobe, per-channel requests and the absolute timestamp.
// Assumes clk is the disciplined clock and pps_raw is asynchronous to it.
module pps_sample_engine #(
    parameter int  DIV     = pps_engine_pkg::DEF_DIV,
    parameter int  SAMPLES = pps_engine_pkg::DEF_SAMPLES,
    parameter int  NCH     = pps_engine_pkg::DEF_NCH,
    parameter int  SEC_W   = pps_engine_pkg::DEF_SEC_W,
    localparam int IDX_W   = pps_engine_pkg::width_of(SAMPLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_raw,
    input  logic             load_en,
    input  logic [SEC_W-1:0] load_sec,
    output logic             sample_strobe,
    output logic [NCH-1:0]   chan_req,
    output logic [IDX_W-1:0] sample_idx,
    output logic [SEC_W-1:0] seconds,
    output logic             pps_seen,
    output logic             pps_missing,
    output logic             short_second
);

    logic boundary;
    logic tick;
    logic run;

    pps_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps_raw  (pps_raw),
        .pps_edge (boundary)
    );

    sample_divider #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (boundary),
        .run     (run),
        .tick    (tick)
    );

    block_sequencer #(.SAMPLES(SAMPLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .boundary  (boundary),
        .tick      (tick),
        .run       (run),
        .strobe    (sample_strobe),
        .idx       (sample_idx),
        .armed     (pps_seen),
        .missing   (pps_missing),
        .short_sec (short_second)
    );

    seconds_counter #(.SEC_W(SEC_W)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .load_en  (load_en),
        .load_sec (load_sec),
        .seconds  (seconds)
    );

    // One request line per channel, all fired by the same strobe
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        always_comb chan_req[ch] = sample_strobe;
    end

    assert_no_strobe_unarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pps_seen |-> !sample_strobe);

    assert_seen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pps_seen |=> pps_seen);

    assert_short_realign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        short_second |-> sample_strobe && sample_idx == '0);

endmodule

// File: tb/test_pps_sample_engine.sv
// Bench for pps_sample_engine: small divide and block size, directed corner
// cases, then seeded random pulse spacing and loads, compared every cycle
// against a reference model written from the requirements.
module test_pps_sample_engine;

    localparam int DIV     = 4;
    localparam int SAMPLES = 6;
    localparam int NCH     = 3;
    localparam int SEC_W   = 16;
    localparam int IDX_W   = 3;
    localparam int BLOCK   = DIV * SAMPLES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pps_raw = 1'b0;
    logic             load_en = 1'b0;
    logic [SEC_W-1:0] load_sec = '0;
    logic             sample_strobe;
    logic [NCH-1:0]   chan_req;
    logic [IDX_W-1:0] sample_idx;
    logic [SEC_W-1:0] seconds;
    logic             pps_seen;
    logic             pps_missing;
    logic             short_second;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    pps_sample_engine #(.DIV(DIV), .SAMPLES(SAMPLES), .NCH(NCH), .SEC_W(SEC_W)) i_pps_sample_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .pps_raw       (pps_raw),
        .load_en       (load_en),
        .load_sec      (load_sec),
        .sample_strobe (sample_strobe),
        .chan_req      (chan_req),
        .sample_idx    (sample_idx),
        .seconds       (seconds),
        .pps_seen      (pps_seen),
        .pps_missing   (pps_missing),
        .short_second  (short_second)
    );

    always #5 clk = ~clk;

    // Reference model state
    logic m_s1, m_s2, m_prev;
    int   m_cnt, m_idx;
    logic m_strobe, m_armed, m_miss, m_short;
    logic [SEC_W-1:0] m_sec, m_pval;
    logic m_pend;

    function automatic logic [SEC_W-1:0] next_seconds(logic pend, logic [SEC_W-1:0] pval,
                                                      logic [SEC_W-1:0] cur);
        return pend ? pval : cur + 1'b1;
    endfunction

    // Cycle model built from R2..R8
    always @(posedge clk) begin
        automatic logic edge_now = m_s2 && !m_prev;
        automatic logic tick_now = m_armed && !m_miss && !edge_now && (m_cnt == DIV - 1);
        automatic logic full_now = (m_idx == SAMPLES - 1);
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_cnt <= 0; m_idx <= 0;
            m_strobe <= 0; m_armed <= 0; m_miss <= 0; m_short <= 0;
            m_sec <= '0; m_pval <= '0; m_pend <= 0;
        end else begin
            m_s1 <= pps_raw; m_s2 <= m_s1; m_prev <= m_s2;
            if (edge_now || !(m_armed && !m_miss) || m_cnt == DIV - 1) m_cnt <= 0;
            else m_cnt <= m_cnt + 1;
            if (load_en) m_pval <= load_sec;
            if (edge_now) begin
                m_idx <= 0; m_strobe <= 1; m_armed <= 1; m_miss <= 0;
                m_short <= m_armed && !full_now;
                m_sec <= next_seconds(m_pend, m_pval, m_sec);
                m_pend <= load_en;
            end else begin
                m_short <= 0;
                m_strobe <= tick_now && !full_now;
                if (tick_now && !full_now) m_idx <= m_idx + 1;
                if (tick_now && full_now) m_miss <= 1;
                if (load_en) m_pend <= 1;
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R3 strobe", sample_strobe, m_strobe);
            chk("R9 chan_req", chan_req, {NCH{m_strobe}});
            chk("R3 sample_idx", sample_idx, m_idx);
            chk("R4/R7 seconds", seconds, m_sec);
            chk("R8 pps_seen", pps_seen, m_armed);
            chk("R5 pps_missing", pps_missing, m_miss);
            chk("R6 short_second", short_second, m_short);
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int width, input int gap);
        pps_raw = 1'b1;
        cyc(width);
        pps_raw = 1'b0;
        cyc(gap);
    endtask

    initial begin
        // R1: reset state
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 strobe after reset", sample_strobe, 0);
        chk("R1 index after reset", sample_idx, 0);
        chk("R1 seconds after reset", seconds, 0);
        chk("R1 flags after reset", {pps_seen, pps_missing, short_second, chan_req}, 0);
        cyc(30);
        chk("R1 no strobe before first boundary", pps_seen | sample_strobe, 0);

        // R2: latency from first high sample to strobe
        pps_raw = 1'b1;
        cyc(2);
        chk("R2 no strobe after two edges", sample_strobe, 0);
        cyc(1);
        chk("R2 strobe after third edge", sample_strobe, 1);
        chk("R2 index zero at first strobe", sample_idx, 0);
        chk("R8 seen at first boundary", pps_seen, 1);
        chk("R4 seconds after first boundary", seconds, 1);
        model_on = 1'b1;

        // R2/R5: held level gives one boundary, block then runs dry
        cyc(BLOCK + 20);
        chk("R5 missing with level held", pps_missing, 1);
        chk("R5 index holds at last", sample_idx, SAMPLES - 1);
        pps_raw = 1'b0;
        cyc(4);

        // R7: load waits for next boundary
        load_en = 1'b1; load_sec = 16'd500;
        cyc(1);
        load_en = 1'b0;
        cyc(3);
        chk("R7 load not applied early", seconds, 1);
        pulse(2, 3);
        chk("R7 load applied at boundary", seconds, 500);
        chk("R5 missing cleared by boundary", pps_missing, 0);

        // R6: early boundary
        cyc(5);
        pulse(2, 0);
        cyc(1);
        chk("R6 short second flagged", short_second, 1);
        cyc(1);
        chk("R6 short second one cycle", short_second, 0);

        // Random spacing and loads, including exact-block spacing
        void'($urandom(32'd1234));
        for (int s = 0; s < 120; s++) begin
            automatic int kind = $urandom_range(0, 3);
            automatic int per = (kind == 0) ? BLOCK :
                                (kind == 1) ? $urandom_range(6, BLOCK - 1) :
                                $urandom_range(BLOCK + 1, BLOCK + 15);
            automatic int w = $urandom_range(2, 5);
            pps_raw = 1'b1;
            for (int c = 0; c < per; c++) begin
                if (c == w) pps_raw = 1'b0;
                load_en = ($urandom_range(0, 19) == 0);
                load_sec = SEC_W'($urandom);
                cyc(1);
            end
            load_en = 1'b0;
        end
        cyc(BLOCK + 10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule